// File: doc/BRIEF.md
# I2C Master START Condition Generator

This block produces the START condition of an I2C master on open-drain SDA and SCL lines and watches for a bus collision while it does so. A one-cycle request pulse begins a START. The block first leaves both lines released and waits one baud phase. It then pulls SDA low and waits a second baud phase. Finally it pulls SCL low. At that point the START is complete and both lines stay held low for the logic that sends the address. Each phase lasts as many clock cycles as a 7-bit reload value gives, and a value of zero counts as one cycle.

The raw pin levels pass through two-flop synchronizers before any decision uses them. A collision ends the attempt. A collision is either line already being low when the request arrives, or SCL falling while SDA is still high in the first phase. On a collision the block releases the lines, clears its busy indication and sets a sticky collision flag. If another master pulls SDA low during the first phase, the block cuts that phase short and drives SDA low at once. SCL going low in the second phase is tolerated. Whenever SDA is seen low while SCL is high, a START-seen status bit and a sticky interrupt flag are set. Software clears the two sticky flags through dedicated clear inputs.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset both drive outputs are low (lines released), and startBusy, startDone, irqFlag, collFlag and startSeen are all 0.
- R2: A startGo pulse taken while idle, with the synchronized SDA or SCL low, sets collFlag on the next edge, leaves both lines released and leaves startBusy at 0.
- R3: A startGo pulse taken while idle, with both synchronized lines high, raises startBusy. sdaDriveLow then rises exactly L edges after the request edge, where L is reloadVal, or 1 when reloadVal is 0.
- R4: In the first phase, a synchronized SCL low while the synchronized SDA is high aborts the START. Both lines stay released, startBusy drops and collFlag is set, all on the edge that evaluates the sample.
- R5: In the first phase, a synchronized SDA low drives SDA low on the evaluating edge. A pin change applied before edge A therefore shows at sdaDriveLow after edge A+2 and not after edge A+1. The second phase then lasts a full L cycles.
- R6: SCL going low during the second phase does not set collFlag and does not change when the START completes.
- R7: sclDriveLow rises L edges after sdaDriveLow. startDone is high for exactly that one cycle, startBusy drops on the same edge, and sdaDriveLow stays high.
- R8: startSeen and irqFlag are set when, during a START attempt (including a request rejected because SDA was low with SCL high), the synchronized SDA is low while the synchronized SCL is high. startSeen clears when a new START is accepted.
- R9: irqFlag and collFlag stay set until their own clear input is pulsed. A clear pulse on the same edge as a set leaves the flag set.
- R10: While a START is running, startGo has no effect on timing. A startGo pulse while both lines are held after completion releases both drives and returns the block to idle without flagging a collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startGo | input | 1 | One-cycle START request (releases the held lines when the block is holding) |
| reloadVal | input | 7 | Baud phase length in cycles (0 means 1) |
| sdaPin | input | 1 | Raw SDA line level |
| sclPin | input | 1 | Raw SCL line level |
| irqClr | input | 1 | Clears irqFlag |
| collClr | input | 1 | Clears collFlag |
| sdaDriveLow | output | 1 | Pull SDA low when 1 |
| sclDriveLow | output | 1 | Pull SCL low when 1 |
| startBusy | output | 1 | START in progress; drops on completion or collision |
| startDone | output | 1 | One-cycle pulse when the START is complete |
| irqFlag | output | 1 | Sticky interrupt flag |
| collFlag | output | 1 | Sticky bus-collision flag |
| startSeen | output | 1 | START condition observed on the bus |

## Verification
A counter that is loaded or decremented wrongly shows up as an SDA or SCL edge that comes early or late by a measurable number of cycles. The bench therefore sweeps reload values and counts the cycles to each drive edge. A phase decision that is wrong shows within three edges of the offending pin change: a missing or spurious collision flag, a busy bit that stays up, or an SDA drive that does not appear. Flag priority errors show on the very edge where a clear meets a set.

// File: rtl/stgen_pkg.sv
package stgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PH1  = 2'd1,
    ST_PH2  = 2'd2,
    ST_HOLD = 2'd3
  } stgenState_t;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic setColl;
    logic watchStart;
    logic clearSeen;
  } stgenStrobe_t;

endpackage

// File: rtl/stgen_datapath.sv
module stgen_datapath
  import stgen_pkg::*;
#(
  parameter int RELOAD_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                sdaPin,
  input  logic                sclPin,
  input  logic                irqClr,
  input  logic                collClr,
  input  stgenStrobe_t        strb,
  output logic                sdaS,
  output logic                sclS,
  output logic                cntLast,
  output logic                irqFlag,
  output logic                collFlag,
  output logic                startSeen
);

  localparam logic [RELOAD_W-1:0] CNT_ONE = RELOAD_W'(1);

  logic [SYNC_STAGES-1:0] sdaSync;
  logic [SYNC_STAGES-1:0] sclSync;
  logic [RELOAD_W-1:0]    cnt;
  logic [RELOAD_W-1:0]    loadVal;
  logic                   startCond;

  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sdaSync <= '1;
          sclSync <= '1;
        end else begin
          sdaSync <= sdaPin;
          sclSync <= sclPin;
        end
      end
    end else begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sdaSync <= '1;
          sclSync <= '1;
        end else begin
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaPin};
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclPin};
        end
      end
    end
  endgenerate

  assign sdaS = sdaSync[SYNC_STAGES-1];
  assign sclS = sclSync[SYNC_STAGES-1];

  // zero reload still yields one cycle per phase
  assign loadVal = (reloadVal == '0) ? CNT_ONE : reloadVal;
  assign cntLast = (cnt == CNT_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= CNT_ONE;
    else if (strb.loadCnt) cnt <= loadVal;
    else if (strb.decCnt)  cnt <= cnt - CNT_ONE;
  end

  assign startCond = strb.watchStart && !sdaS && sclS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag   <= 1'b0;
      collFlag  <= 1'b0;
      startSeen <= 1'b0;
    end else begin
      if (startCond)   irqFlag <= 1'b1;
      else if (irqClr) irqFlag <= 1'b0;
      if (strb.setColl) collFlag <= 1'b1;
      else if (collClr) collFlag <= 1'b0;
      if (startCond)           startSeen <= 1'b1;
      else if (strb.clearSeen) startSeen <= 1'b0;
    end
  end

  assert_cnt_floor_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> (cnt != '0));
  assert_coll_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.setColl |=> collFlag);
  assert_coll_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (collFlag && !collClr) |=> collFlag);
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);

endmodule

// File: rtl/stgen_ctrl.sv
module stgen_ctrl
  import stgen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startGo,
  input  logic         sdaS,
  input  logic         sclS,
  input  logic         cntLast,
  output stgenStrobe_t strb,
  output logic         sdaDriveLow,
  output logic         sclDriveLow,
  output logic         startBusy,
  output logic         startDone
);

  stgenState_t state, stateNext;
  logic        linesHigh;

  assign linesHigh = sdaS && sclS;

  always_comb begin
    stateNext       = state;
    strb            = '0;
    strb.watchStart = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (startGo) begin
          if (linesHigh) begin
            strb.loadCnt   = 1'b1;
            strb.clearSeen = 1'b1;
            stateNext      = ST_PH1;
          end else begin
            strb.setColl    = 1'b1;
            strb.watchStart = 1'b1;
          end
        end
      end
      ST_PH1: begin
        if (sdaS && !sclS) begin
          strb.setColl = 1'b1;
          stateNext    = ST_IDLE;
        end else if (!sdaS || cntLast) begin
          strb.loadCnt = 1'b1;
          stateNext    = ST_PH2;
        end else begin
          strb.decCnt = 1'b1;
        end
      end
      ST_PH2: begin
        if (cntLast) stateNext   = ST_HOLD;
        else         strb.decCnt = 1'b1;
      end
      ST_HOLD: begin
        if (startGo) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      startDone <= 1'b0;
    end else begin
      state     <= stateNext;
      startDone <= (state == ST_PH2) && cntLast;
    end
  end

  assign sdaDriveLow = (state == ST_PH2) || (state == ST_HOLD);
  assign sclDriveLow = (state == ST_HOLD);
  assign startBusy   = (state == ST_PH1) || (state == ST_PH2);

  assert_req_coll_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startGo && !linesHigh) |=> (!sdaDriveLow && !startBusy));
  assert_ph1_abort_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PH1 && sdaS && !sclS) |=> (!startBusy && !sdaDriveLow));
  assert_early_sda_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PH1 && !sdaS) |=> sdaDriveLow);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    startDone |=> !startDone);
  assert_done_with_scl_R7: assert property (@(posedge clk) disable iff (!rstN)
    startDone |-> (sclDriveLow && sdaDriveLow && !startBusy));

endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import stgen_pkg::*;
#(
  parameter int RELOAD_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startGo,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                sdaPin,
  input  logic                sclPin,
  input  logic                irqClr,
  input  logic                collClr,
  output logic                sdaDriveLow,
  output logic                sclDriveLow,
  output logic                startBusy,
  output logic                startDone,
  output logic                irqFlag,
  output logic                collFlag,
  output logic                startSeen
);

  stgenStrobe_t strb;
  logic         sdaS;
  logic         sclS;
  logic         cntLast;

  stgen_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startGo     (startGo),
    .sdaS        (sdaS),
    .sclS        (sclS),
    .cntLast     (cntLast),
    .strb        (strb),
    .sdaDriveLow (sdaDriveLow),
    .sclDriveLow (sclDriveLow),
    .startBusy   (startBusy),
    .startDone   (startDone)
  );

  stgen_datapath #(
    .RELOAD_W    (RELOAD_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reloadVal (reloadVal),
    .sdaPin    (sdaPin),
    .sclPin    (sclPin),
    .irqClr    (irqClr),
    .collClr   (collClr),
    .strb      (strb),
    .sdaS      (sdaS),
    .sclS      (sclS),
    .cntLast   (cntLast),
    .irqFlag   (irqFlag),
    .collFlag  (collFlag),
    .startSeen (startSeen)
  );

endmodule

// File: tb/i2c_start_gen_bench.sv
module i2c_start_gen_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startGo = 1'b0;
  logic [6:0] reloadVal = 7'd0;
  logic       extSda = 1'b1;
  logic       extScl = 1'b1;
  logic       irqClr = 1'b0;
  logic       collClr = 1'b0;
  logic       sdaDriveLow, sclDriveLow, startBusy, startDone;
  logic       irqFlag, collFlag, startSeen;
  logic       sdaPin, sclPin;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  // open-drain wired lines
  assign sdaPin = extSda & ~sdaDriveLow;
  assign sclPin = extScl & ~sclDriveLow;

  i2c_start_gen u_i2c_start_gen (
    .clk(clk), .rstN(rstN), .startGo(startGo), .reloadVal(reloadVal),
    .sdaPin(sdaPin), .sclPin(sclPin), .irqClr(irqClr), .collClr(collClr),
    .sdaDriveLow(sdaDriveLow), .sclDriveLow(sclDriveLow), .startBusy(startBusy),
    .startDone(startDone), .irqFlag(irqFlag), .collFlag(collFlag), .startSeen(startSeen)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseGo();
    startGo = 1'b1;
    @(negedge clk);
    startGo = 1'b0;
  endtask

  task automatic pulseClr(input logic isColl);
    if (isColl) collClr = 1'b1; else irqClr = 1'b1;
    @(negedge clk);
    collClr = 1'b0;
    irqClr  = 1'b0;
  endtask

  // release held lines and let synchronizers settle
  task automatic releaseBus();
    pulseGo();
    check("R10 release sda", int'(sdaDriveLow), 0);
    check("R10 release scl", int'(sclDriveLow), 0);
    nclk(4);
  endtask

  // full START at a given reload; returns cycle latencies
  task automatic runStart(input int r, output int sdaLat, output int sclLat, output int donePulse);
    reloadVal = 7'(r);
    pulseGo();
    sdaLat = 0;
    while (!sdaDriveLow && sdaLat < 400) begin
      sdaLat++;
      @(negedge clk);
    end
    sclLat = 0;
    while (!sclDriveLow && sclLat < 400) begin
      sclLat++;
      @(negedge clk);
    end
    donePulse = int'(startDone);
    @(negedge clk);
    donePulse = donePulse + 2 * int'(startDone);
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int sl, cl, dp, expL;
    nclk(3);
    // R1 reset state
    check("R1 sdaDriveLow", int'(sdaDriveLow), 0);
    check("R1 sclDriveLow", int'(sclDriveLow), 0);
    check("R1 flags", int'({startBusy, startDone, irqFlag, collFlag, startSeen}), 0);
    rstN = 1'b1;
    nclk(3);

    // R3 R7 sweep of reload values
    for (int r = 0; r <= 13; r++) begin
      int rv;
      rv = (r == 13) ? 127 : r;
      expL = (rv == 0) ? 1 : rv;
      runStart(rv, sl, cl, dp);
      check($sformatf("R3 sda latency reload=%0d", rv), sl, expL);
      check($sformatf("R7 scl latency reload=%0d", rv), cl, expL);
      check($sformatf("R7 done single pulse reload=%0d", rv), dp, 1);
      check("R7 busy dropped", int'(startBusy), 0);
      check("R7 sda held", int'(sdaDriveLow), 1);
      nclk(3);
      check("R8 startSeen after START", int'(startSeen), 1);
      check("R8 irqFlag after START", int'(irqFlag), 1);
      check("R6 no collision", int'(collFlag), 0);
      pulseClr(1'b0);
      check("R9 irq cleared", int'(irqFlag), 0);
      releaseBus();
    end

    // R9 sticky irq holds without clear
    runStart(2, sl, cl, dp);
    nclk(10);
    check("R9 irq sticky", int'(irqFlag), 1);
    pulseClr(1'b0);
    releaseBus();

    // R2 request with SDA low, SCL high
    extSda = 1'b0;
    nclk(3);
    reloadVal = 7'd5;
    pulseGo();
    check("R2 coll on sda low", int'(collFlag), 1);
    check("R2 busy stays 0", int'(startBusy), 0);
    check("R2 lines released", int'({sdaDriveLow, sclDriveLow}), 0);
    check("R8 startSeen on sda-low request", int'(startSeen), 1);
    check("R8 irq on sda-low request", int'(irqFlag), 1);
    nclk(5);
    check("R9 coll sticky", int'(collFlag), 1);
    pulseClr(1'b1);
    check("R9 coll cleared", int'(collFlag), 0);
    pulseClr(1'b0);
    extSda = 1'b1;
    nclk(3);

    // R2 request with SCL low; R9 clear on same edge loses
    extScl = 1'b0;
    nclk(3);
    startGo = 1'b1;
    collClr = 1'b1;
    @(negedge clk);
    startGo = 1'b0;
    collClr = 1'b0;
    check("R9 set wins over clear", int'(collFlag), 1);
    check("R2 busy stays 0 scl low", int'(startBusy), 0);
    check("R8 no irq when scl low", int'(irqFlag), 0);
    pulseClr(1'b1);
    extScl = 1'b1;
    nclk(3);

    // R4 SCL low in phase 1
    reloadVal = 7'd20;
    pulseGo();
    nclk(5);
    extScl = 1'b0;
    nclk(2);
    check("R4 busy before evaluation", int'(startBusy), 1);
    check("R4 coll before evaluation", int'(collFlag), 0);
    nclk(1);
    check("R4 abort busy", int'(startBusy), 0);
    check("R4 coll set", int'(collFlag), 1);
    check("R4 lines released", int'({sdaDriveLow, sclDriveLow}), 0);
    extScl = 1'b1;
    pulseClr(1'b1);
    nclk(3);

    // R5 other master pulls SDA low in phase 1
    reloadVal = 7'd20;
    pulseGo();
    nclk(5);
    extSda = 1'b0;
    nclk(2);
    check("R5 not yet after A+1", int'(sdaDriveLow), 0);
    nclk(1);
    check("R5 early sda drive", int'(sdaDriveLow), 1);
    check("R5 no collision", int'(collFlag), 0);
    extSda = 1'b1;
    cl = 0;
    while (!sclDriveLow && cl < 400) begin
      cl++;
      @(negedge clk);
    end
    check("R5 full second phase", cl, 20);
    nclk(2);
    check("R8 startSeen early path", int'(startSeen), 1);
    pulseClr(1'b0);
    releaseBus();

    // R6 SCL low during phase 2; R10 startGo ignored mid-run
    reloadVal = 7'd10;
    pulseGo();
    nclk(3);
    pulseGo();
    sl = 4;
    while (!sdaDriveLow && sl < 400) begin
      sl++;
      @(negedge clk);
    end
    check("R10 startGo ignored in phase 1", sl, 10);
    extScl = 1'b0;
    nclk(4);
    extScl = 1'b1;
    cl = 4;
    while (!sclDriveLow && cl < 400) begin
      cl++;
      @(negedge clk);
    end
    check("R6 completion time", cl, 10);
    check("R6 no collision", int'(collFlag), 0);
    check("R7 done with scl", int'(startDone), 1);
    nclk(5);
    check("R10 hold persists", int'({sdaDriveLow, sclDriveLow}), 3);
    releaseBus();
    check("R10 no coll on release", int'(collFlag), 0);
    check("R10 idle after release", int'(startBusy), 0);

    // R8 new accepted START clears startSeen at acceptance
    check("R8 startSeen still set", int'(startSeen), 1);
    reloadVal = 7'd8;
    pulseGo();
    check("R8 startSeen cleared on accept", int'(startSeen), 0);
    nclk(20);
    releaseBus();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule